// File: doc/BRIEF.md
# Sample Playback Busy Timer

This block is the control port of a small cartridge sound channel. The CPU writes a single byte to one fixed address. A write whose upper nibble is nonzero starts, or restarts, a playback interval. Its lower nibble is then sent to a downstream sample decoder. A write whose upper nibble is zero cancels playback and sends nothing.

While an interval is active, a down-counter runs on a per-cycle tick. When it runs out, the interval ends by itself and the counter refills. Software polls the same address to see whether the channel is still busy. Only one status bit is driven. Every other bit of the returned byte is the value left floating on the data bus.

The code output is a push-only stream with a valid strobe and no ready. The decoder must accept each code in the cycle it is presented. Codes cannot be held back, because the CPU write that produces them cannot be stalled. At most one code is produced per clock cycle.

Top module: `pcm_busy_timer`

## Requirements
- R1: A write (`cpu_wr` high) to address `PORT_ADDR` (0x5800) whose data bits [7:4] are not all zero sets `play_active` from the next cycle on and emits data bits [3:0] on `code_data`.
- R2: A write to `PORT_ADDR` whose data bits [7:4] are zero clears `play_active` from the next cycle on and emits no code, whatever bits [3:0] hold.
- R3: While `play_active` is high, each clock edge with `cycle_tick` high decrements the interval counter. The edge that takes it from 1 to 0 instead refills it to `WINDOW` (0x3F6 = 1014) and clears `play_active`. A fresh interval therefore lasts exactly `WINDOW` ticks.
- R4: Edges with `cycle_tick` low, and all edges while `play_active` is low, leave the counter and `play_active` unchanged.
- R5: A cancel or a restart does not refill the counter. Ticks already used are lost, so the ticks used across cancel and restart add up to `WINDOW`.
- R6: While `cpu_rd` is high at `PORT_ADDR`, `rd_data` equals `bus_in` with bit 6 replaced by the inverse of `play_active` (1 = idle, 0 = busy).
- R7: Writes to any other address change neither `play_active` nor `code_valid`. Reads of any other address, or with `cpu_rd` low, return `bus_in` unchanged.
- R8: `code_valid` is high for exactly the one cycle after the edge that accepts a start write, with `code_data` holding that write's low nibble.
- R9: After reset, `play_active` and `code_valid` are low and the counter holds `WINDOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one accepted write per high cycle |
| cpu_rd | input | 1 | Read strobe |
| bus_in | input | 8 | Floating data bus value for reads |
| cycle_tick | input | 1 | Per-CPU-cycle count enable |
| rd_data | output | 8 | Read data returned to the CPU |
| code_valid | output | 1 | Code stream valid strobe |
| code_data | output | 4 | Code for the sample decoder |
| play_active | output | 1 | Playback interval in progress |

## Verification
The checker watches these rules on every cycle:
- a start write raises the active flag and produces a matching code one cycle later;
- a cancel lowers the flag without producing a code;
- every code strobe traces back to a start write;
- the flag never falls unless a tick or a cancel came first;
- stray writes elsewhere while idle disturb nothing.

Some properties only show up over whole scenarios, so the bench measures them: the exact interval length in ticks, the carry-over of spent ticks across cancel and restart, the pause while ticks are withheld, and the bit-6 merge on reads.

// File: rtl/pcm_timer_pkg.sv
package pcm_timer_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_START  = 2'd1,
    CMD_CANCEL = 2'd2
  } snd_cmd_e;
endpackage

// File: rtl/pcm_port_decode.sv
module pcm_port_decode
  import pcm_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  output snd_cmd_e          cmd,
  output logic              code_valid,
  output logic [DATA_W/2-1:0] code_data
);
  localparam int NIB_W = DATA_W / 2;

  logic             hit;
  logic [NIB_W-1:0] upper;
  logic [NIB_W-1:0] lower;

  assign hit   = cpu_wr && (cpu_addr == PORT_ADDR);
  assign upper = cpu_wdata[DATA_W-1:NIB_W];
  assign lower = cpu_wdata[NIB_W-1:0];

  // Classify the write; a nonzero command nibble means start.
  always_comb begin
    cmd = CMD_IDLE;
    if (hit) cmd = (upper != '0) ? CMD_START : CMD_CANCEL;
  end

  // One-cycle code strobe toward the decoder.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_data  <= '0;
    end else begin
      code_valid <= (cmd == CMD_START);
      if (cmd == CMD_START) code_data <= lower;
    end
  end
endmodule

// File: rtl/pcm_window_counter.sv
module pcm_window_counter
  import pcm_timer_pkg::*;
#(
  parameter int WINDOW = 1014,
  parameter int CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  snd_cmd_e cmd,
  input  logic     cycle_tick,
  output logic     active
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic             step;
  logic             expire;

  assign step   = active && cycle_tick;
  assign expire = step && (count <= LAST);

  // Interval counter: never refilled by commands, only on expiry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= RELOAD;
    end else if (expire) begin
      count <= RELOAD;
    end else if (step) begin
      count <= count - LAST;
    end
  end

  // Commands take priority over expiry in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_START:  active <= 1'b1;
        CMD_CANCEL: active <= 1'b0;
        default:    if (expire) active <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcm_status_mux.sv
module pcm_status_mux #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STATUS_BIT = 6,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5800
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              active,
  output logic [DATA_W-1:0] rd_data
);
  logic sel;
  assign sel = cpu_rd && (cpu_addr == PORT_ADDR);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == STATUS_BIT) begin : g_status
      assign rd_data[b] = sel ? ~active : bus_in[b];
    end else begin : g_pass
      assign rd_data[b] = bus_in[b];
    end
  end
endmodule

// File: rtl/pcm_busy_timer.sv
module pcm_busy_timer
  import pcm_timer_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int WINDOW     = 1014,
  parameter int STATUS_BIT = 6,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [DATA_W-1:0]   bus_in,
  input  logic                cycle_tick,
  output logic [DATA_W-1:0]   rd_data,
  output logic                code_valid,
  output logic [DATA_W/2-1:0] code_data,
  output logic                play_active
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  snd_cmd_e cmd;

  pcm_port_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cmd(cmd), .code_valid(code_valid), .code_data(code_data)
  );

  pcm_window_counter #(
    .WINDOW(WINDOW), .CNT_W(CNT_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cycle_tick(cycle_tick),
    .active(play_active)
  );

  pcm_status_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_BIT(STATUS_BIT),
    .PORT_ADDR(PORT_ADDR)
  ) u_status (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .bus_in(bus_in),
    .active(play_active), .rd_data(rd_data)
  );
endmodule

// File: rtl/pcm_busy_timer_chk.sv
module pcm_busy_timer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5800
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic [DATA_W-1:0]   cpu_wdata,
  input logic                cpu_wr,
  input logic                cycle_tick,
  input logic                code_valid,
  input logic [DATA_W/2-1:0] code_data,
  input logic                play_active
);
  localparam int NIB_W = DATA_W / 2;

  logic hit, start_w, cancel_w;
  assign hit      = cpu_wr && (cpu_addr == PORT_ADDR);
  assign start_w  = hit && (cpu_wdata[DATA_W-1:NIB_W] != '0);
  assign cancel_w = hit && (cpu_wdata[DATA_W-1:NIB_W] == '0);

  p_start_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> play_active && code_valid && code_data == $past(cpu_wdata[NIB_W-1:0]));

  p_cancel_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_w |=> !play_active && !code_valid);

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(play_active) |-> $past(cycle_tick) || $past(cancel_w));

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (play_active && !cycle_tick && !hit) |=> play_active);

  p_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr != PORT_ADDR && !play_active) |=> !play_active && !code_valid);

  p_code_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(start_w));
endmodule

bind pcm_busy_timer pcm_busy_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cycle_tick(cycle_tick), .code_valid(code_valid),
  .code_data(code_data), .play_active(play_active)
);

// File: tb/pcm_busy_timer_test.sv
module pcm_busy_timer_test;
  localparam int W = 1014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  bus_in = '0;
  logic        cycle_tick = 1'b1;
  logic [7:0]  rd_data;
  logic        code_valid;
  logic [3:0]  code_data;
  logic        play_active;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  logic [3:0] exp_q[$];

  always #4 clk = ~clk;

  pcm_busy_timer uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .bus_in(bus_in), .cycle_tick(cycle_tick),
    .rd_data(rd_data), .code_valid(code_valid), .code_data(code_data),
    .play_active(play_active)
  );

  // Counts edges that should consume one tick of the interval.
  always @(posedge clk) if (rst_n && play_active && cycle_tick) tick_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compare every code strobe with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && code_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected code", 1, 0);
      else check("R1 code value", int'(code_data), int'(exp_q.pop_front()));
    end
  end

  // Driver: one write; afterwards we sit at the negedge after the edge.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    if (a == 16'h5800 && d[7:4] != 4'h0) exp_q.push_back(d[3:0]);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (play_active) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] b, output logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; bus_in = b; cpu_rd = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 active", play_active, 0);
    check("R9 code_valid", code_valid, 0);
    rd(16'h5800, 8'h00, v);
    check("R6/R9 idle status", v, 8'h40);

    // R1 + R3: fresh interval lasts W ticks
    base = tick_cnt;
    wr(16'h5800, 8'h37);
    check("R1 active set", play_active, 1);
    check("R8 pulse present", code_valid, 1);
    @(negedge clk);
    check("R8 pulse one cycle", code_valid, 0);
    rd(16'h5800, 8'hFF, v);
    check("R6 busy status", v, 8'hBF);
    wait_idle();
    check("R3 interval length", tick_cnt - base, W);

    // R7: other addresses ignored, read passes bus
    wr(16'h5801, 8'hF5);
    check("R7 stray write active", play_active, 0);
    wr(16'h5FFF, 8'h9A);
    check("R7 stray write active 2", play_active, 0);
    rd(16'h5801, 8'hA5, v);
    check("R7 read passthrough", v, 8'hA5);
    @(negedge clk); cpu_addr = 16'h5800; bus_in = 8'h12; #1;
    check("R7 no strobe passthrough", rd_data, 8'h12);

    // R2: cancel with nonzero low nibble emits no code
    wr(16'h5800, 8'h81);
    wr(16'h5800, 8'h0A);
    check("R2 cancel clears", play_active, 0);
    check("R2 no code", code_valid, 0);
    rd(16'h5800, 8'h3C, v);
    check("R6 idle merge", v, 8'h7C);
    // refill: run a fresh start to expiry
    wr(16'h5800, 8'h10);
    wait_idle();

    // R5: carry-over across cancel and restart
    base = tick_cnt;
    wr(16'h5800, 8'hC4);
    repeat (300) @(negedge clk);
    wr(16'h5800, 8'h00);
    repeat (20) @(negedge clk);
    check("R4 idle holds counter", play_active, 0);
    wr(16'h5800, 8'h2B);
    repeat (10) @(negedge clk);
    wr(16'h5800, 8'hF6);
    check("R5 restart while active", play_active, 1);
    wait_idle();
    check("R5 carried total", tick_cnt - base, W);

    // R4: no ticks, no progress
    @(negedge clk); cycle_tick = 1'b0;
    base = tick_cnt;
    wr(16'h5800, 8'h55);
    repeat (1200) @(negedge clk);
    check("R4 held without ticks", play_active, 1);
    cycle_tick = 1'b1;
    wait_idle();
    check("R4 full window after pause", tick_cnt - base, W);

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule